// File: doc/BRIEF.md
# Serial Port Data Buffers with Status Flags and Interrupt Requests

This block sits between a processor's register port and the two shift engines of a serial port. It keeps one holding byte for each direction. The transmit holding byte is written by the processor and drained by the transmit shifter. The receive holding byte is filled by the receive shifter and drained by the processor. Each byte has a status flag: transmit-buffer-empty and receive-buffer-full. A two-bit enable register gates those flags onto two separate interrupt request lines, so that each request can reach its own vector.

The requests are levels, not latched events. A request stays high while its flag and its enable are both set. It drops when software clears the enable, or when software makes the data access that clears the flag: writing the transmit byte, or reading the receive byte.

The transmit shifter side is a valid/ready stream. `txs_valid` is high while the holding byte is full, and a byte moves when `txs_valid` and `txs_ready` are both high on a clock edge. The receive shifter side is a valid-only stream, because the block never applies back-pressure. A byte offered on `rxs_valid` is always taken. If the previous byte has not been read yet, it is overwritten and the overrun flag is set.

Top module: `uart_buf_irq`

## Requirements
- R1: After reset, `tx_empty`=1, `rx_full`=0, `rx_overrun`=0, `ctl_rdata`=2'b00, and both interrupt requests are 0.
- R2: A pulse on `ctl_wr` loads `ctl_wdata` into the enable register. Bit 1 is the transmit interrupt enable and bit 0 is the receive interrupt enable. `ctl_rdata` returns the register from the next cycle onward.
- R3: A pulse on `cpu_tx_wr` stores `cpu_tx_data` and clears `tx_empty` on the next cycle. `txs_valid` is the inverse of `tx_empty` and `txs_data` shows the stored byte. A write while the byte is still full replaces it.
- R4: A cycle with `txs_valid` and `txs_ready` both high sets `tx_empty` on the next cycle. If `cpu_tx_wr` is high in the same cycle, the write wins: `tx_empty` stays 0 and the new byte is held. `txs_ready` has no effect while `txs_valid` is 0.
- R5: `irq_tx` equals `tx_empty` AND enable bit 1 at all times. It follows a flag or enable change in the cycle after the causing input.
- R6: A pulse on `rxs_valid` stores `rxs_data` into the receive byte (`cpu_rx_data`) and sets `rx_full` on the next cycle.
- R7: A pulse on `cpu_rx_rd` clears `rx_full` on the next cycle. If `rxs_valid` is high in the same cycle, the new byte is stored and `rx_full` stays 1. A read while `rx_full` is 0 leaves the byte and the flag unchanged.
- R8: `rxs_valid` while `rx_full` is 1 and no read is made in that cycle sets `rx_overrun` and replaces the byte. Any `cpu_rx_rd` that does not coincide with such an overrun clears `rx_overrun`.
- R9: `irq_rx` equals `rx_full` AND enable bit 0 at all times.
- R10: The two requests are independent. Receive-side activity never changes `irq_tx`, and transmit-side activity never changes `irq_rx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_tx_wr | input | 1 | Processor write strobe for the transmit byte |
| cpu_tx_data | input | DATA_W | Byte written to the transmit holding register |
| cpu_rx_rd | input | 1 | Processor read strobe for the receive byte |
| cpu_rx_data | output | DATA_W | Receive holding byte |
| ctl_wr | input | 1 | Enable register write strobe |
| ctl_wdata | input | 2 | Enable register write data ([1] transmit, [0] receive) |
| ctl_rdata | output | 2 | Enable register readback |
| tx_empty | output | 1 | Transmit holding byte is empty |
| rx_full | output | 1 | Receive holding byte is full |
| rx_overrun | output | 1 | A byte was overwritten before it was read |
| txs_valid | output | 1 | Transmit byte available to the shifter |
| txs_ready | input | 1 | Transmit shifter takes the byte |
| txs_data | output | DATA_W | Transmit byte to the shifter |
| rxs_valid | input | 1 | Receive shifter delivers a byte |
| rxs_data | input | DATA_W | Byte from the receive shifter |
| irq_tx | output | 1 | Transmit-buffer-empty interrupt request |
| irq_rx | output | 1 | Receive-buffer-full interrupt request |

## Verification
Every piece of state in the block is visible at the ports one cycle after the input that changes it. A wrong flag shows at once as a wrong `tx_empty`, `rx_full` or `rx_overrun`. It also shows as a request that is stuck high or missing whenever the matching enable is set. A wrong data byte shows on `txs_data` or `cpu_rx_data` in the cycle after the write or delivery. The bench therefore compares every output after every cycle against an arithmetic model. It sweeps all enable values against each flag state, all byte values, and the same-cycle collisions of a write with a take and of a read with a delivery.

// File: rtl/uart_bufirq_pkg.sv
package uart_bufirq_pkg;
  localparam int CTL_W     = 2;
  localparam int EN_RX_BIT = 0;
  localparam int EN_TX_BIT = 1;
  localparam int NUM_IRQ   = 2;
  localparam int IRQ_RX    = 0;
  localparam int IRQ_TX    = 1;
endpackage

// File: rtl/ubi_txbuf.sv
module ubi_txbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              take_rdy,
  output logic              take_vld,
  output logic [DATA_W-1:0] data,
  output logic              empty
);
  logic              empty_q;
  logic [DATA_W-1:0] byte_q;
  logic              take;

  // A take only counts while a byte is held.
  assign take = take_rdy & ~empty_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      empty_q <= 1'b1;
      byte_q  <= '0;
    end else begin
      if (wr) begin
        // A write wins over a same-cycle take.
        byte_q  <= wdata;
        empty_q <= 1'b0;
      end else if (take) begin
        empty_q <= 1'b1;
      end
    end
  end

  assign take_vld = ~empty_q;
  assign data     = byte_q;
  assign empty    = empty_q;
endmodule

// File: rtl/ubi_rxbuf.sv
module ubi_rxbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              put,
  input  logic [DATA_W-1:0] put_data,
  input  logic              rd,
  output logic [DATA_W-1:0] data,
  output logic              full,
  output logic              overrun
);
  logic              full_q;
  logic              ovr_q;
  logic [DATA_W-1:0] byte_q;
  logic              lost;

  // A byte is lost only if it arrives on an unread, full buffer.
  assign lost = put & full_q & ~rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      byte_q <= '0;
    end else begin
      if (put) begin
        byte_q <= put_data;
        full_q <= 1'b1;
      end else if (rd) begin
        full_q <= 1'b0;
      end
      if (lost)    ovr_q <= 1'b1;
      else if (rd) ovr_q <= 1'b0;
    end
  end

  assign data    = byte_q;
  assign full    = full_q;
  assign overrun = ovr_q;
endmodule

// File: rtl/ubi_irqctl.sv
module ubi_irqctl
  import uart_bufirq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [CTL_W-1:0]   wdata,
  output logic [CTL_W-1:0]   en,
  input  logic [NUM_IRQ-1:0] cond,
  output logic [NUM_IRQ-1:0] req
);
  logic [CTL_W-1:0] en_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  en_q <= '0;
    else if (wr) en_q <= wdata;
  end

  assign en = en_q;

  // One level request per source; the index map is fixed in the package.
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_gate
    localparam int EB = (i == IRQ_TX) ? EN_TX_BIT : EN_RX_BIT;
    assign req[i] = cond[i] & en_q[EB];
  end
endmodule

// File: rtl/uart_buf_irq.sv
module uart_buf_irq
  import uart_bufirq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_tx_wr,
  input  logic [DATA_W-1:0] cpu_tx_data,
  input  logic              cpu_rx_rd,
  output logic [DATA_W-1:0] cpu_rx_data,
  input  logic              ctl_wr,
  input  logic [1:0]        ctl_wdata,
  output logic [1:0]        ctl_rdata,
  output logic              tx_empty,
  output logic              rx_full,
  output logic              rx_overrun,
  output logic              txs_valid,
  input  logic              txs_ready,
  output logic [DATA_W-1:0] txs_data,
  input  logic              rxs_valid,
  input  logic [DATA_W-1:0] rxs_data,
  output logic              irq_tx,
  output logic              irq_rx
);
  logic [NUM_IRQ-1:0] cond;
  logic [NUM_IRQ-1:0] req;

  ubi_txbuf #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .wr(cpu_tx_wr), .wdata(cpu_tx_data),
    .take_rdy(txs_ready), .take_vld(txs_valid),
    .data(txs_data), .empty(tx_empty)
  );

  ubi_rxbuf #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .put(rxs_valid), .put_data(rxs_data),
    .rd(cpu_rx_rd), .data(cpu_rx_data),
    .full(rx_full), .overrun(rx_overrun)
  );

  assign cond[IRQ_TX] = tx_empty;
  assign cond[IRQ_RX] = rx_full;

  ubi_irqctl u_irq (
    .clk(clk), .rst_n(rst_n),
    .wr(ctl_wr), .wdata(ctl_wdata), .en(ctl_rdata),
    .cond(cond), .req(req)
  );

  assign irq_tx = req[IRQ_TX];
  assign irq_rx = req[IRQ_RX];
endmodule

// File: rtl/uart_buf_irq_chk.sv
module uart_buf_irq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_tx_wr,
  input logic              cpu_rx_rd,
  input logic [DATA_W-1:0] cpu_rx_data,
  input logic              ctl_wr,
  input logic [1:0]        ctl_wdata,
  input logic              tx_empty,
  input logic              rx_full,
  input logic              rx_overrun,
  input logic              txs_valid,
  input logic              txs_ready,
  input logic              rxs_valid,
  input logic [DATA_W-1:0] rxs_data,
  input logic              irq_tx,
  input logic              irq_rx
);
  assert_wr_clears_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_tx_wr |=> !tx_empty && txs_valid);
  assert_take_sets_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (txs_valid && txs_ready && !cpu_tx_wr) |=> tx_empty);
  assert_write_drops_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_tx_wr |=> !irq_tx);
  assert_irq_tx_needs_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx |-> tx_empty);
  assert_rx_stores_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rxs_valid |=> rx_full && cpu_rx_data == $past(rxs_data));
  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rx_rd && !rxs_valid) |=> !rx_full && !irq_rx);
  assert_overrun_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rxs_valid && rx_full && !cpu_rx_rd) |=> rx_overrun);
  assert_irq_rx_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |-> rx_full);
  assert_disable_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_wdata == 2'b00) |=> !irq_tx && !irq_rx);
  assert_tx_quiet_on_rx_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_tx_wr && !txs_ready && !ctl_wr) |=> $stable(irq_tx));
endmodule

bind uart_buf_irq uart_buf_irq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cpu_tx_wr(cpu_tx_wr), .cpu_rx_rd(cpu_rx_rd), .cpu_rx_data(cpu_rx_data),
  .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
  .tx_empty(tx_empty), .rx_full(rx_full), .rx_overrun(rx_overrun),
  .txs_valid(txs_valid), .txs_ready(txs_ready),
  .rxs_valid(rxs_valid), .rxs_data(rxs_data),
  .irq_tx(irq_tx), .irq_rx(irq_rx)
);

// File: tb/uart_buf_irq_bench.sv
module uart_buf_irq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_tx_wr = 0, cpu_rx_rd = 0, ctl_wr = 0, txs_ready = 0, rxs_valid = 0;
  logic [7:0] cpu_tx_data = 0, rxs_data = 0;
  logic [1:0] ctl_wdata = 0;
  logic [7:0] cpu_rx_data, txs_data;
  logic [1:0] ctl_rdata;
  logic       tx_empty, rx_full, rx_overrun, txs_valid, irq_tx, irq_rx;

  int checks = 0;
  int errors = 0;

  // Reference state, built from the requirements
  logic       m_empty = 1, m_full = 0, m_ovr = 0;
  logic [7:0] m_tbuf = 0, m_rbuf = 0;
  logic [1:0] m_en = 0;

  always #10 clk = ~clk;

  uart_buf_irq u_uart_buf_irq (.*);

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "tx_empty", {7'd0, tx_empty}, {7'd0, m_empty});
    chk(req, "txs_valid", {7'd0, txs_valid}, {7'd0, ~m_empty});
    chk(req, "txs_data", txs_data, m_tbuf);
    chk(req, "rx_full", {7'd0, rx_full}, {7'd0, m_full});
    chk(req, "rx_overrun", {7'd0, rx_overrun}, {7'd0, m_ovr});
    chk(req, "cpu_rx_data", cpu_rx_data, m_rbuf);
    chk(req, "ctl_rdata", {6'd0, ctl_rdata}, {6'd0, m_en});
    chk(req, "irq_tx", {7'd0, irq_tx}, {7'd0, m_empty & m_en[1]});
    chk(req, "irq_rx", {7'd0, irq_rx}, {7'd0, m_full & m_en[0]});
  endtask

  // One clock with the given strobes, then a model update and a full check.
  task automatic cyc(input string req, input logic wr, input logic [7:0] wd, input logic tr,
                     input logic rv, input logic [7:0] rd_b, input logic rd,
                     input logic cw, input logic [1:0] cd);
    logic take, lost;
    cpu_tx_wr = wr; cpu_tx_data = wd; txs_ready = tr;
    rxs_valid = rv; rxs_data = rd_b; cpu_rx_rd = rd;
    ctl_wr = cw; ctl_wdata = cd;
    take = tr & ~m_empty;
    lost = rv & m_full & ~rd;
    @(posedge clk); #1;
    cpu_tx_wr = 0; txs_ready = 0; rxs_valid = 0; cpu_rx_rd = 0; ctl_wr = 0;
    if (wr) begin m_tbuf = wd; m_empty = 0; end
    else if (take) m_empty = 1;
    if (rv) begin m_rbuf = rd_b; m_full = 1; end
    else if (rd) m_full = 0;
    if (lost) m_ovr = 1; else if (rd) m_ovr = 0;
    if (cw) m_en = cd;
    check_all(req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_all("R1");
    rst_n = 1;
    @(posedge clk); #1;
    check_all("R1");

    // R2/R5/R9: all enable values against every flag combination
    for (int e = 0; e < 4; e++) begin
      cyc("R2", 0, 0, 0, 0, 0, 0, 1, 2'(e));
      cyc("R5", 0, 0, 0, 0, 0, 0, 0, 0);
      cyc("R9", 0, 0, 0, 1, 8'h5A, 0, 0, 0);
      cyc("R5", 1, 8'hC3, 0, 0, 0, 0, 0, 0);
      cyc("R10", 0, 0, 0, 0, 0, 1, 0, 0);
      cyc("R4", 0, 0, 1, 0, 0, 0, 0, 0);
    end

    cyc("R2", 0, 0, 0, 0, 0, 0, 1, 2'b11);
    // R3/R4/R6/R7: every byte value through both paths
    for (int b = 0; b < 256; b++) begin
      cyc("R3", 1, 8'(b), 0, 0, 0, 0, 0, 0);
      cyc("R4", 0, 0, 1, 1, 8'(255 - b), 0, 0, 0);
      cyc("R7", 0, 0, 0, 0, 0, 1, 0, 0);
    end

    // Collisions and ignored strobes
    cyc("R4", 0, 0, 1, 0, 0, 0, 0, 0);          // take while empty: no effect
    cyc("R3", 1, 8'h11, 0, 0, 0, 0, 0, 0);
    cyc("R3", 1, 8'h22, 0, 0, 0, 0, 0, 0);      // overwrite while full
    cyc("R4", 1, 8'h33, 1, 0, 0, 0, 0, 0);      // write wins over take
    cyc("R7", 0, 0, 0, 0, 0, 1, 0, 0);          // read while empty: no effect
    cyc("R6", 0, 0, 0, 1, 8'hA1, 0, 0, 0);
    cyc("R8", 0, 0, 0, 1, 8'hA2, 0, 0, 0);      // overrun
    cyc("R8", 0, 0, 0, 1, 8'hA3, 0, 0, 0);      // still overrun
    cyc("R7", 0, 0, 0, 1, 8'hA4, 1, 0, 0);      // read + deliver: stays full, ovr clears
    cyc("R8", 0, 0, 0, 0, 0, 1, 0, 0);
    cyc("R10", 0, 0, 0, 1, 8'h77, 0, 0, 0);
    cyc("R10", 0, 0, 1, 0, 0, 0, 0, 0);
    cyc("R2", 0, 0, 0, 0, 0, 0, 1, 2'b00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule